// File: doc/BRIEF.md
# Tunnel Header Encapsulator with Realignment

This block wraps an Ethernet frame in an outer tunnel header on its way into a packet buffer. The frame comes in as a stream of 32-bit words. Each word carries a valid flag, and the stream marks the first word, the last word and the number of valid bytes in that last word. The block first sends out the outer header, which it builds from configuration inputs: an outer destination MAC address, an outer source MAC address, a tunnel Ethertype and a 4-byte shim. It then sends out the inner frame. The output uses the same word format and honours ready/valid backpressure.

The outer header is 18 bytes long, which is two bytes short of a whole number of words. In compact mode the inner frame therefore has to be moved by a half word: each output word takes the held low half of the previous input word followed by the upper half of the current one. In padded mode a 2-byte zero filler follows the shim. The header then fills five whole words and the inner words pass through untouched. Padded mode gives up two bytes per frame so that the payload keeps its 4-byte alignment in the buffer.

Top module: `tunnel_encap`

## Requirements
- R1: The first four output words of a frame are {dst[47:16]}, {dst[15:0], src[47:32]}, {src[31:0]} and {ethertype, shim[31:16]}. The first of them is the only word flagged as start of frame.
- R2: In compact mode (pad select 0) the fifth word is {shim[15:0], inner bytes 0..1}. The rest of the inner frame follows shifted by two bytes, so a frame of N inner bytes gives exactly 18+N output bytes in order.
- R3: In padded mode (pad select 1) the fifth word is {shim[15:0], 16'h0000}. The inner words follow unchanged, so a frame of N inner bytes gives 20+N output bytes.
- R4: In compact mode, if the last input word holds 3 or 4 valid bytes, one extra output word follows, carrying (count - 2) bytes. If it holds 1 or 2 bytes, the last shifted word carries (count + 2) bytes. A frame always takes ceil(total bytes / 4) output words.
- R5: The byte-count field is 3 bits wide, and the values 1 to 4 mean that many leading bytes. Every output word that is not the last reports 4. The input count is read only on the last input word and is ignored on all others.
- R6: Input ready is low while header words or the extra trailing word are being sent. In the cycle after the last word of a frame is accepted, output valid is low.
- R7: While output valid is high and output ready is low, the output word and its flags stay unchanged, and no input or output word is lost or repeated.
- R8: The pad select is sampled when a frame starts. Changing it during a frame has no effect on that frame.
- R9: During reset, and right after it, output valid and input ready are low.
- R10: Bytes are big-endian within a word: the first byte in time sits in bits 31:24.
- R11: A word offered between frames without the start flag is taken and dropped, and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dst_mac | input | 48 | Outer destination MAC address |
| cfg_src_mac | input | 48 | Outer source MAC address |
| cfg_tun_type | input | 16 | Tunnel Ethertype |
| cfg_shim | input | 32 | Tunnel shim |
| cfg_align_pad | input | 1 | 1 = insert the 2-byte filler (padded mode) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 32 | Input word, big-endian |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_bytes | input | 3 | Valid bytes in the last word (1..4) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Output word, big-endian |
| out_sof | output | 1 | First output word of a frame |
| out_eof | output | 1 | Last output word of a frame |
| out_bytes | output | 3 | Valid bytes in the output word |

## Verification
The bench builds the block with its default 32-bit word and 3-bit byte count. At that width the two header lengths, 18 and 20 bytes, fall on opposite sides of a word boundary, so both the shifting path and the pass-through path are exercised. Inner lengths from 1 to 70 bytes run the last input word through all four byte counts in both modes. That covers every form of the extra trailing word and every end-of-frame count. Random gaps on the input and random backpressure on the output hold the header, body and trailing states stalled across edges, and frames that toggle the pad select in mid-flight exercise the sampling at frame start.

// File: rtl/tunnel_encap_pkg.sv
package tunnel_encap_pkg;

  localparam int MAC_W   = 48;
  localparam int ETYPE_W = 16;
  localparam int SHIM_W  = 32;
  localparam int FILL_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR0 = 3'd1,
    ST_HDR1 = 3'd2,
    ST_HDR2 = 3'd3,
    ST_HDR3 = 3'd4,
    ST_HDR4 = 3'd5,
    ST_BODY = 3'd6,
    ST_TAIL = 3'd7
  } enc_state_e;

endpackage

// File: rtl/encap_hdr_gen.sv
module encap_hdr_gen
  import tunnel_encap_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  enc_state_e           state,
  input  logic [MAC_W-1:0]     dst_mac,
  input  logic [MAC_W-1:0]     src_mac,
  input  logic [ETYPE_W-1:0]   tun_type,
  input  logic [SHIM_W-1:0]    shim,
  output logic [WORD_W-1:0]    hdr_word
);

  localparam int HDR_BITS = 2*MAC_W + ETYPE_W + SHIM_W + FILL_W;
  localparam int N_WORDS  = HDR_BITS / WORD_W;

  logic [HDR_BITS-1:0] hdr_vec;
  logic [WORD_W-1:0]   words [N_WORDS];

  assign hdr_vec = {dst_mac, src_mac, tun_type, shim, {FILL_W{1'b0}}};

  generate
    for (genvar k = 0; k < N_WORDS; k++) begin : g_slice
      assign words[k] = hdr_vec[HDR_BITS-1-k*WORD_W -: WORD_W];
    end
  endgenerate

  always_comb begin
    case (state)
      ST_HDR0: hdr_word = words[0];
      ST_HDR1: hdr_word = words[1];
      ST_HDR2: hdr_word = words[2];
      ST_HDR3: hdr_word = words[3];
      ST_HDR4: hdr_word = words[4];
      default: hdr_word = '0;
    endcase
  end

endmodule

// File: rtl/encap_ctrl.sv
module encap_ctrl
  import tunnel_encap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_align_pad,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [CNT_W-1:0] in_bytes,
  input  logic             out_ready,
  output enc_state_e       state,
  output logic             pad_q,
  output logic [CNT_W-1:0] tail_cnt,
  output logic             in_ready,
  output logic             in_fire,
  output logic             out_valid
);

  localparam logic [CNT_W-1:0] HALF_BYTES = CNT_W'(WORD_W / 16);

  enc_state_e       state_q, state_d;
  logic             pad_en, pad_d;
  logic             tail_en;
  logic [CNT_W-1:0] tail_q, tail_d;

  assign state    = state_q;
  assign tail_cnt = tail_q;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    case (state_q)
      ST_IDLE: in_ready = in_valid & ~in_sof;
      ST_HDR0, ST_HDR1, ST_HDR2, ST_HDR3, ST_HDR4: out_valid = 1'b1;
      ST_BODY: begin
        in_ready  = out_ready;
        out_valid = in_valid;
      end
      ST_TAIL: out_valid = 1'b1;
      default: ;
    endcase
  end

  assign in_fire = in_valid & in_ready;

  always_comb begin
    state_d = state_q;
    pad_en  = 1'b0;
    pad_d   = pad_q;
    tail_en = 1'b0;
    tail_d  = tail_q;
    case (state_q)
      ST_IDLE: if (in_valid && in_sof) begin
        state_d = ST_HDR0;
        pad_en  = 1'b1;
        pad_d   = cfg_align_pad;
      end
      ST_HDR0: if (out_ready) state_d = ST_HDR1;
      ST_HDR1: if (out_ready) state_d = ST_HDR2;
      ST_HDR2: if (out_ready) state_d = ST_HDR3;
      ST_HDR3: if (out_ready) state_d = pad_q ? ST_HDR4 : ST_BODY;
      ST_HDR4: if (out_ready) state_d = ST_BODY;
      ST_BODY: if (in_fire && in_eof) begin
        if (!pad_q && (in_bytes > HALF_BYTES)) begin
          state_d = ST_TAIL;
          tail_en = 1'b1;
          tail_d  = in_bytes - HALF_BYTES;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_TAIL: if (out_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pad_q   <= 1'b0;
      tail_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pad_en)  pad_q  <= pad_d;
      if (tail_en) tail_q <= tail_d;
    end
  end

endmodule

// File: rtl/encap_datapath.sv
module encap_datapath
  import tunnel_encap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  enc_state_e         state,
  input  logic               pad_q,
  input  logic [WORD_W-1:0]  hdr_word,
  input  logic [WORD_W/2-1:0] shim_lo,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_eof,
  input  logic [CNT_W-1:0]   in_bytes,
  input  logic               in_fire,
  input  logic [CNT_W-1:0]   tail_cnt,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_sof,
  output logic               out_eof,
  output logic [CNT_W-1:0]   out_bytes
);

  localparam int               HALF_W     = WORD_W / 2;
  localparam logic [CNT_W-1:0] FULL_BYTES = CNT_W'(WORD_W / 8);
  localparam logic [CNT_W-1:0] HALF_BYTES = CNT_W'(WORD_W / 16);

  logic              hold_en;
  logic [HALF_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_en = 1'b0;
    hold_d  = hold_q;
    if (state == ST_HDR3 && out_ready) begin
      hold_en = 1'b1;
      hold_d  = shim_lo;
    end else if (state == ST_BODY && in_fire) begin
      hold_en = 1'b1;
      hold_d  = in_data[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_comb begin
    out_data  = '0;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    out_bytes = FULL_BYTES;
    case (state)
      ST_HDR0, ST_HDR1, ST_HDR2, ST_HDR3, ST_HDR4: begin
        out_data = hdr_word;
        out_sof  = (state == ST_HDR0);
      end
      ST_BODY: begin
        if (pad_q) begin
          out_data = in_data;
          out_eof  = in_eof;
          if (in_eof) out_bytes = in_bytes;
        end else begin
          out_data = {hold_q, in_data[WORD_W-1:HALF_W]};
          if (in_eof && (in_bytes <= HALF_BYTES)) begin
            out_eof   = 1'b1;
            out_bytes = in_bytes + HALF_BYTES;
          end
        end
      end
      ST_TAIL: begin
        out_data  = {hold_q, {HALF_W{1'b0}}};
        out_eof   = 1'b1;
        out_bytes = tail_cnt;
      end
      default: out_bytes = '0;
    endcase
  end

endmodule

// File: rtl/tunnel_encap.sv
module tunnel_encap
  import tunnel_encap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [47:0]        cfg_dst_mac,
  input  logic [47:0]        cfg_src_mac,
  input  logic [15:0]        cfg_tun_type,
  input  logic [31:0]        cfg_shim,
  input  logic               cfg_align_pad,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [CNT_W-1:0]   in_bytes,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_sof,
  output logic               out_eof,
  output logic [CNT_W-1:0]   out_bytes
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  enc_state_e       state;
  logic             pad_q;
  logic [CNT_W-1:0] tail_cnt;
  logic             in_fire;
  logic [WORD_W-1:0] hdr_word;

  encap_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cfg_align_pad (cfg_align_pad),
    .in_valid      (in_valid),
    .in_sof        (in_sof),
    .in_eof        (in_eof),
    .in_bytes      (in_bytes),
    .out_ready     (out_ready),
    .state         (state),
    .pad_q         (pad_q),
    .tail_cnt      (tail_cnt),
    .in_ready      (in_ready),
    .in_fire       (in_fire),
    .out_valid     (out_valid)
  );

  encap_hdr_gen #(.WORD_W(WORD_W)) u_hdr (
    .state    (state),
    .dst_mac  (cfg_dst_mac),
    .src_mac  (cfg_src_mac),
    .tun_type (cfg_tun_type),
    .shim     (cfg_shim),
    .hdr_word (hdr_word)
  );

  encap_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state     (state),
    .pad_q     (pad_q),
    .hdr_word  (hdr_word),
    .shim_lo   (cfg_shim[WORD_W/2-1:0]),
    .in_data   (in_data),
    .in_eof    (in_eof),
    .in_bytes  (in_bytes),
    .in_fire   (in_fire),
    .tail_cnt  (tail_cnt),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_bytes (out_bytes)
  );

endmodule

// File: rtl/encap_checker.sv
module encap_checker #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_sof,
  input logic              out_eof,
  input logic [CNT_W-1:0]  out_bytes
);

  localparam logic [CNT_W-1:0] FULL_BYTES = CNT_W'(WORD_W / 8);

  // R6: the first header word never coincides with an input acceptance
  p_hdr_blocks_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !in_ready);

  // R7: a stalled first header word is held unchanged
  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && out_sof |=> out_valid && out_sof && $stable(out_data));

  // R1: after the first header word is taken, more header follows at once
  p_hdr_continues_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_sof |=> out_valid && !out_sof && !out_eof);

  // R5: every word that is not the last is full
  p_full_words_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eof |-> out_bytes == FULL_BYTES);

  // R5: last word count within 1..4
  p_last_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |-> (out_bytes != '0) && (out_bytes <= FULL_BYTES));

  // R6: idle in the cycle after the end of a frame
  p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> !out_valid);

endmodule

bind tunnel_encap encap_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .out_bytes (out_bytes)
);

// File: tb/tunnel_encap_test.sv
`timescale 1ns/1ps
module tunnel_encap_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] cfg_dst_mac, cfg_src_mac;
  logic [15:0] cfg_tun_type;
  logic [31:0] cfg_shim;
  logic        cfg_align_pad;
  logic        in_valid, in_ready, in_sof, in_eof;
  logic [31:0] in_data;
  logic [2:0]  in_bytes;
  logic        out_valid, out_ready, out_sof, out_eof;
  logic [31:0] out_data;
  logic [2:0]  out_bytes;

  always #5 clk = ~clk;

  tunnel_encap uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_dst_mac(cfg_dst_mac), .cfg_src_mac(cfg_src_mac),
    .cfg_tun_type(cfg_tun_type), .cfg_shim(cfg_shim), .cfg_align_pad(cfg_align_pad),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_bytes(out_bytes)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] exp_q[$];
  int         exp_len_q[$];
  bit         exp_mode_q[$];
  logic [7:0] got_q[$];
  int         got_words = 0;
  bit         bp_en = 1'b0;
  bit         stall_pend = 1'b0;
  logic [31:0] stall_data;
  bit         stall_eof;
  logic [2:0] stall_bytes;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // expected header bytes, first byte on the wire first (R10)
  function automatic void push_header(input bit pad);
    logic [143:0] h;
    h = {cfg_dst_mac, cfg_src_mac, cfg_tun_type, cfg_shim};
    for (int i = 0; i < 18; i++) exp_q.push_back(h[143-8*i -: 8]);
    if (pad) begin
      exp_q.push_back(8'h00);
      exp_q.push_back(8'h00);
    end
  endfunction

  task automatic compare_frame();
    int  len;
    bit  mode;
    bit  ok;
    int  bad;
    logic [7:0] e, a;
    string req;
    len  = exp_len_q.pop_front();
    mode = exp_mode_q.pop_front();
    req  = mode ? "R3" : "R2";
    check(got_q.size() == len, req, "frame byte length", got_q.size(), len);
    ok = 1'b1; bad = 0; e = 0; a = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] ev;
      ev = exp_q.pop_front();
      if (ok && i < got_q.size() && got_q[i] !== ev) begin
        ok = 1'b0; bad = i; e = ev; a = got_q[i];
      end
    end
    check(ok, req, $sformatf("R10 byte %0d", bad), a, e);
    check(got_words == (len + 3) / 4, "R4", "output word count", got_words, (len + 3) / 4);
    got_q.delete();
    got_words = 0;
  endtask

  // monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_pend) begin
        check(out_valid && out_data == stall_data && out_eof == stall_eof &&
              out_bytes == stall_bytes, "R7", "stalled word changed", out_data, stall_data);
      end
      stall_pend  = out_valid && !out_ready;
      stall_data  = out_data;
      stall_eof   = out_eof;
      stall_bytes = out_bytes;
      if (out_valid && out_ready) begin
        check(out_sof == (got_words == 0), "R1", "start flag", out_sof, got_words == 0);
        if (out_sof) check(!in_ready, "R6", "input ready during header", in_ready, 0);
        if (!out_eof) check(out_bytes == 3'd4, "R5", "non-last count", out_bytes, 4);
        for (int b = 0; b < int'(out_bytes) && b < 4; b++)
          got_q.push_back(out_data[31-8*b -: 8]);
        got_words++;
        if (out_eof) compare_frame();
      end
    end
  end

  // backpressure
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_en ? (($urandom % 100) >= 35) : 1'b1;
    end
  end

  task automatic offer_word(input logic [31:0] d, input bit s, input bit e,
                            input logic [2:0] nb);
    in_data = d; in_sof = s; in_eof = e; in_bytes = nb; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input int n, input bit pad, input bit flip, input int gap_pct);
    logic [7:0] fb[$];
    int nw;
    for (int i = 0; i < n; i++) fb.push_back(8'($urandom));
    cfg_align_pad = pad;
    push_header(pad);
    foreach (fb[i]) exp_q.push_back(fb[i]);
    exp_len_q.push_back(n + (pad ? 20 : 18));
    exp_mode_q.push_back(pad);
    nw = (n + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      bit last;
      logic [2:0] nb;
      d = $urandom;
      for (int b = 0; b < 4; b++)
        if (4*w + b < n) d[31-8*b -: 8] = fb[4*w + b];
      last = (w == nw - 1);
      nb = last ? 3'(n - 4*w) : 3'($urandom);  // R5: count ignored on non-last
      while (int'($urandom % 100) < gap_pct) begin
        @(posedge clk); #1;
      end
      offer_word(d, w == 0, last, nb);
      if (w == 0 && flip) cfg_align_pad = ~pad;  // R8
    end
  endtask

  task automatic drain();
    while (exp_len_q.size() != 0) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic new_cfg();
    cfg_dst_mac  = {$urandom, $urandom};
    cfg_src_mac  = {$urandom, $urandom};
    cfg_tun_type = 16'($urandom);
    cfg_shim     = $urandom;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_bytes = '0; in_data = '0;
    cfg_align_pad = 1'b0;
    new_cfg();
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready, "R9", "outputs in reset", {out_valid, in_ready}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !in_ready, "R9", "outputs after reset", {out_valid, in_ready}, 0);
    @(posedge clk); #1;

    // R11: stray words without the start flag are dropped
    offer_word(32'hDEADBEEF, 1'b0, 1'b0, 3'd4);
    offer_word(32'hCAFEF00D, 1'b0, 1'b1, 3'd2);
    repeat (3) @(negedge clk);
    check(!out_valid && got_words == 0, "R11", "stray word produced output", out_valid, 0);
    @(posedge clk); #1;

    // directed sweep, every length, both modes, no backpressure
    for (int pad = 0; pad < 2; pad++)
      for (int n = 1; n <= 70; n++) send_frame(n, pad[0], 1'b0, 0);
    drain();

    // R8: mode flipped mid-frame
    for (int n = 1; n <= 12; n++) send_frame(n, n[0], 1'b1, 0);
    drain();

    // random phase with backpressure and new configuration
    new_cfg();
    bp_en = 1'b1;
    for (int k = 0; k < 300; k++)
      send_frame(1 + int'($urandom % 70), 1'($urandom), ($urandom % 5) == 0, 25);
    drain();
    new_cfg();
    for (int k = 0; k < 100; k++)
      send_frame(1 + int'($urandom % 8), 1'($urandom), 1'b0, 10);
    drain();
    check(exp_q.size() == 0, "R2", "leftover expected bytes", exp_q.size(), 0);
    finish_run();
  end

endmodule